// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache with Store Queue

This block sits between a processor word port and a single memory port. It keeps a direct-mapped array of cache lines, each holding a block of words under one tag and one valid bit. A read that finds its tag in the indexed line returns data in the same cycle. A read that misses stalls the processor until the whole block has been fetched from memory and installed.

Stores follow a write-through, no-allocate policy. A store that hits overwrites the cached word. A store that misses leaves the cache untouched. In both cases the store is put into a small first-in first-out store queue. The queue empties to memory in the background whenever the memory port is free. Because every store reaches memory, memory always ends up holding the latest value. A store stalls the processor only while the queue is full.

A read miss does not fetch its block until the queue is completely empty. This means a fetch can never return a value that an older store has not yet written. Two counters report the cycles the processor spent stalled on full-queue stores and on read misses.

Top module: `wt_cache`

## Requirements
- R1: After reset, `cpu_stall_o` and `mem_req_o` are low, both stall counters read zero, and every line is invalid, so the first read of any address misses.
- R2: When a read hits a valid line with a matching tag, `cpu_stall_o` stays low and `cpu_rdata_o` carries the cached word in the same cycle.
- R3: A read miss stalls the processor and reads every word of the block from memory. The reads start at the block base (word offset 0 in address bit 0 with the default `OFF_W`=1) and go in ascending order. The block is then installed, and the held read completes with the fetched word.
- R4: A store that hits updates the cached word. A following read of that address returns the new data without stalling.
- R5: A store that misses does not install a line. A following read of that address misses.
- R6: Every accepted store is written to memory exactly once, and stores reach memory in the order they were accepted. The address and write enable of a pending memory request stay constant until `mem_ack_i`.
- R7: While the store queue holds fewer than `WB_DEPTH` entries, a store completes in its first cycle without stalling.
- R8: While the queue is full, a store stalls until an entry has drained. Every such stall cycle increments `st_stall_cnt_o`.
- R9: A block fetch for a read miss is issued only when the store queue is empty. A read that misses right after a store to the same address returns the stored data.
- R10: Every cycle in which a read is held stalled increments `rd_stall_cnt_o`.
- R11: Two addresses with the same index but different tags evict each other, so alternating reads between them both miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_req_i | input | 1 | Access request, held until `cpu_stall_o` is low |
| cpu_we_i | input | 1 | 1 = store, 0 = read |
| cpu_addr_i | input | ADDR_W | Word address: offset in low bits, then index, then tag |
| cpu_wdata_i | input | DATA_W | Store data |
| cpu_rdata_o | output | DATA_W | Read data, valid when a read is not stalled |
| cpu_stall_o | output | 1 | Access cannot complete this cycle |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | 1 = queue drain write, 0 = block fetch read |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_wdata_o | output | DATA_W | Write data for a drain |
| mem_ack_i | input | 1 | Transfer completes in this cycle |
| mem_rdata_i | input | DATA_W | Read data, valid with `mem_ack_i` |
| st_stall_cnt_o | output | CNT_W | Cycles stalled on a full store queue |
| rd_stall_cnt_o | output | CNT_W | Cycles stalled on read misses |

## Verification
Suppose a tag or valid bit is corrupted. The next read to that line shows it at once: either `cpu_stall_o` rises for a read that should hit, or stale data comes back with no stall. A queue pointer that is off by one shows up only when the queue drains, as a missing, repeated or reordered write on the memory port. For that reason the memory writes are logged and compared against the order in which stores were accepted. A miss ordered wrongly against the queue is caught on the read itself: reading an address straight after storing to it returns the old memory value.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DRAIN = 2'd1,
    ST_FILL  = 2'd2
  } wtc_state_e;
endpackage

// File: rtl/wtc_wbuf.sv
module wtc_wbuf #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic [ADDR_W-1:0] head_addr_o,
  output logic [DATA_W-1:0] head_data_o,
  output logic              empty_o,
  output logic              full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  cnt_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) begin
      addr_q[wr_ptr_q] <= addr_i;
      data_q[wr_ptr_q] <= data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= nxt(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= nxt(rd_ptr_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_addr_o = addr_q[rd_ptr_q];
  assign head_data_o = data_q[rd_ptr_q];
  assign empty_o     = (cnt_q == '0);
  assign full_o      = (cnt_q == CNT_W'(DEPTH));

  // R8: the cache never pushes into a full queue
  a_r8_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  // R6: drain never pops an empty queue
  a_r6_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/wtc_lines.sv
module wtc_lines #(
  parameter int IDX_W  = 3,
  parameter int OFF_W  = 1,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [OFF_W-1:0]  rd_off_i,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [OFF_W-1:0]  wr_off_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              set_i,
  input  logic [IDX_W-1:0]  set_idx_i,
  input  logic [TAG_W-1:0]  set_tag_i
);
  localparam int LINES = 1 << IDX_W;
  localparam int WORDS = LINES << OFF_W;

  logic [DATA_W-1:0] data_q [WORDS];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [LINES-1:0]  valid_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) data_q[{wr_idx_i, wr_off_i}] <= wr_data_i;
    if (set_i)   tag_q[set_idx_i] <= set_tag_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    valid_q <= '0;
    else if (set_i) valid_q[set_idx_i] <= 1'b1;
  end

  assign rd_tag_o   = tag_q[rd_idx_i];
  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_data_o  = data_q[{rd_idx_i, rd_off_i}];
endmodule

// File: rtl/wt_cache.sv
module wt_cache
  import wtc_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 3,
  parameter int OFF_W    = 1,
  parameter int WB_DEPTH = 4,
  parameter int CNT_W    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              cpu_stall_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [CNT_W-1:0]  st_stall_cnt_o,
  output logic [CNT_W-1:0]  rd_stall_cnt_o
);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  logic [OFF_W-1:0] a_off;
  logic [IDX_W-1:0] a_idx;
  logic [TAG_W-1:0] a_tag;
  assign a_off = cpu_addr_i[OFF_W-1:0];
  assign a_idx = cpu_addr_i[OFF_W +: IDX_W];
  assign a_tag = cpu_addr_i[ADDR_W-1 -: TAG_W];

  wtc_state_e       state_q, state_d;
  logic [OFF_W-1:0] fill_off_q;
  logic [IDX_W-1:0] miss_idx_q;
  logic [TAG_W-1:0] miss_tag_q;
  logic [CNT_W-1:0] st_cnt_q, rd_cnt_q;

  logic [TAG_W-1:0]  line_tag;
  logic              line_valid, hit;
  logic [DATA_W-1:0] line_data;
  logic              rd_req, wr_req, rd_stall, st_stall;
  logic              wb_push, wb_pop, wb_empty, wb_full;
  logic [ADDR_W-1:0] wb_addr;
  logic [DATA_W-1:0] wb_data;
  logic              filling, fill_ack, fill_last;
  logic              arr_we;
  logic [IDX_W-1:0]  arr_idx;
  logic [OFF_W-1:0]  arr_off;
  logic [DATA_W-1:0] arr_data;

  assign hit      = line_valid && (line_tag == a_tag);
  assign rd_req   = cpu_req_i && !cpu_we_i;
  assign wr_req   = cpu_req_i && cpu_we_i;
  assign rd_stall = rd_req && ((state_q != ST_IDLE) || !hit);
  assign st_stall = wr_req && wb_full;
  assign wb_push  = wr_req && !wb_full;

  assign filling   = (state_q == ST_FILL);
  assign fill_ack  = filling && mem_ack_i;
  assign fill_last = (fill_off_q == '1);
  assign wb_pop    = !filling && !wb_empty && mem_ack_i;

  // refill has the port only after the queue has emptied
  assign mem_req_o   = filling || !wb_empty;
  assign mem_we_o    = !filling;
  assign mem_addr_o  = filling ? {miss_tag_q, miss_idx_q, fill_off_q} : wb_addr;
  assign mem_wdata_o = wb_data;

  assign arr_we   = fill_ack || (wb_push && hit);
  assign arr_idx  = filling ? miss_idx_q : a_idx;
  assign arr_off  = filling ? fill_off_q : a_off;
  assign arr_data = filling ? mem_rdata_i : cpu_wdata_i;

  wtc_lines #(.IDX_W(IDX_W), .OFF_W(OFF_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lines (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (a_idx),
    .rd_off_i   (a_off),
    .rd_tag_o   (line_tag),
    .rd_valid_o (line_valid),
    .rd_data_o  (line_data),
    .wr_en_i    (arr_we),
    .wr_idx_i   (arr_idx),
    .wr_off_i   (arr_off),
    .wr_data_i  (arr_data),
    .set_i      (fill_ack && fill_last),
    .set_idx_i  (miss_idx_q),
    .set_tag_i  (miss_tag_q)
  );

  wtc_wbuf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(WB_DEPTH)) u_wbuf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (wb_push),
    .addr_i      (cpu_addr_i),
    .data_i      (cpu_wdata_i),
    .pop_i       (wb_pop),
    .head_addr_o (wb_addr),
    .head_data_o (wb_data),
    .empty_o     (wb_empty),
    .full_o      (wb_full)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (rd_req && !hit) state_d = wb_empty ? ST_FILL : ST_DRAIN;
      ST_DRAIN: if (wb_empty) state_d = ST_FILL;
      ST_FILL:  if (fill_ack && fill_last) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      fill_off_q <= '0;
      miss_idx_q <= '0;
      miss_tag_q <= '0;
      st_cnt_q   <= '0;
      rd_cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && rd_req && !hit) begin
        miss_idx_q <= a_idx;
        miss_tag_q <= a_tag;
        fill_off_q <= '0;
      end else if (fill_ack) begin
        fill_off_q <= fill_off_q + 1'b1;
      end
      if (st_stall) st_cnt_q <= st_cnt_q + 1'b1;
      if (rd_stall) rd_cnt_q <= rd_cnt_q + 1'b1;
    end
  end

  assign cpu_rdata_o    = line_data;
  assign cpu_stall_o    = rd_stall || st_stall;
  assign st_stall_cnt_o = st_cnt_q;
  assign rd_stall_cnt_o = rd_cnt_q;

  // R9: block fetch only with an empty store queue
  a_r9_fetch_after_drain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |-> wb_empty);
  // R8: a store is held back only by a full queue
  a_r8_store_stall_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_stall_o && cpu_req_i && cpu_we_i) |-> wb_full);
  // R6: memory request held steady until acknowledged
  a_r6_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));
endmodule

// File: tb/tb_wt_cache.sv
module tb_wt_cache;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam int MW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_req = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic [DW-1:0] cpu_rdata;
  logic          cpu_stall;
  logic          mem_req, mem_we, mem_ack = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata = '0;
  logic [15:0]   st_cnt, rd_cnt;

  always #5 clk = ~clk;

  wt_cache dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr),
    .cpu_wdata_i(cpu_wdata), .cpu_rdata_o(cpu_rdata), .cpu_stall_o(cpu_stall),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .st_stall_cnt_o(st_cnt), .rd_stall_cnt_o(rd_cnt)
  );

  logic [DW-1:0] mem_arr [MW];
  logic [DW-1:0] ref_mem [MW];
  logic [AW-1:0] wlog [256];
  logic [AW-1:0] rlog [256];
  int wlog_n = 0, rlog_n = 0, st_done = 0, lat = 3, wait_c = 0;
  int st_stall_sum = 0, rd_stall_sum = 0;
  bit r9_bad = 1'b0;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  // memory model: ack after lat request cycles
  always @(posedge clk) begin
    if (mem_ack) begin
      mem_ack <= 1'b0;
      wait_c  <= 0;
      if (mem_we) begin
        mem_arr[mem_addr] <= mem_wdata;
        wlog[wlog_n[7:0]] <= mem_addr;
        wlog_n <= wlog_n + 1;
      end else begin
        rlog[rlog_n[7:0]] <= mem_addr;
        rlog_n <= rlog_n + 1;
        if (wlog_n != st_done) r9_bad <= 1'b1;
      end
    end else if (mem_req && rst_n) begin
      if (wait_c >= lat - 1) begin
        mem_ack   <= 1'b1;
        mem_rdata <= mem_arr[mem_addr];
      end else begin
        wait_c <= wait_c + 1;
      end
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [AW-1:0] a, input bit exp_miss, input string req);
    int cyc = 0;
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a;
    #1;
    while (cpu_stall && cyc < 5000) begin
      @(negedge clk); #1; cyc++;
    end
    rd_stall_sum += cyc;
    check({req, " miss/hit"}, 64'(cyc != 0), 64'(exp_miss));
    check({req, " rdata"}, 64'(cpu_rdata), 64'(ref_mem[a]));
    @(negedge clk);
    cpu_req = 1'b0;
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, output int cyc);
    cyc = 0;
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    #1;
    while (cpu_stall && cyc < 5000) begin
      @(negedge clk); #1; cyc++;
    end
    st_stall_sum += cyc;
    @(posedge clk);
    ref_mem[a] = d;
    st_done++;
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic wait_drain();
    int g = 0;
    while (wlog_n != st_done && g < 5000) begin
      @(negedge clk); g++;
    end
  endtask

  task automatic t_reset();
    #1;
    check("R1 stall", 64'(cpu_stall), 0);
    check("R1 mem_req", 64'(mem_req), 0);
    check("R1 counters", 64'({st_cnt, rd_cnt}), 0);
  endtask

  task automatic t_miss_then_hit();
    int r0 = rlog_n;
    do_read(12'h010, 1'b1, "R3 first read");
    check("R3 fetch count", 64'(rlog_n - r0), 2);
    check("R3 fetch word0", 64'(rlog[r0[7:0]]), 64'(12'h010));
    check("R3 fetch word1", 64'(rlog[8'(r0 + 1)]), 64'(12'h011));
    do_read(12'h011, 1'b0, "R2 same-block hit");
    do_read(12'h010, 1'b0, "R2 repeat hit");
  endtask

  task automatic t_store_hit();
    int c;
    do_write(12'h011, 32'hCAFE_0011, c);
    check("R7 store no stall", 64'(c), 0);
    do_read(12'h011, 1'b0, "R4 read after store hit");
    wait_drain();
    check("R6 memory updated", 64'(mem_arr[12'h011]), 64'(32'hCAFE_0011));
  endtask

  task automatic t_store_miss_then_read();
    int c;
    // 0x200 maps to line 0 like 0x010 but with another tag
    do_write(12'h200, 32'h1234_5678, c);
    do_read(12'h200, 1'b1, "R5 R9 read after store miss");
    check("R9 fetch after drain", 64'(r9_bad), 0);
    do_read(12'h010, 1'b1, "R11 evicted conflict");
    do_read(12'h200, 1'b1, "R11 evicted again");
  endtask

  task automatic t_order();
    int c, stall_any = 0, base;
    logic [AW-1:0] al [4];
    al[0] = 12'h031; al[1] = 12'h102; al[2] = 12'h031; al[3] = 12'h7F3;
    lat = 1;
    wait_drain();
    base = wlog_n;
    for (int i = 0; i < 4; i++) begin
      do_write(al[i], 32'hA000_0000 + 32'(i), c);
      stall_any += c;
    end
    check("R7 four stores no stall", 64'(stall_any), 0);
    wait_drain();
    for (int i = 0; i < 4; i++)
      check("R6 drain order", 64'(wlog[8'(base + i)]), 64'(al[i]));
    check("R6 last write wins", 64'(mem_arr[12'h031]), 64'(32'hA000_0002));
  endtask

  task automatic t_full();
    int c, tot = 0;
    lat = 8;
    wait_drain();
    for (int i = 0; i < 6; i++) begin
      do_write(12'h400 + 12'(i), 32'hB000_0000 + 32'(i), c);
      if (i < 4) check("R7 store with room", 64'(c), 0);
      tot += c;
    end
    check("R8 full queue stalled", 64'(tot > 0), 1);
    check("R8 store stall counter", 64'(st_cnt), 64'(st_stall_sum));
    wait_drain();
    for (int i = 0; i < 6; i++)
      check("R6 all stores reached memory", 64'(mem_arr[12'h400 + 12'(i)]), 64'(32'hB000_0000 + 32'(i)));
    lat = 3;
  endtask

  task automatic t_counters_and_rereset();
    check("R10 read stall counter", 64'(rd_cnt), 64'(rd_stall_sum));
    wait_drain();
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rd_stall_sum = 0;
    st_stall_sum = 0;
    t_reset();
    do_read(12'h011, 1'b1, "R1 lines invalid after reset");
  endtask

  initial begin
    for (int i = 0; i < MW; i++) begin
      mem_arr[i] = 32'h5A00_0000 ^ (32'(i) * 32'h0001_9E37);
      ref_mem[i] = mem_arr[i];
    end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_miss_then_hit();
    t_store_hit();
    t_store_miss_then_read();
    t_order();
    t_full();
    t_counters_and_rereset();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule